// File: doc/BRIEF.md
# Paged Management Register File for a Pluggable Module

This block is the slave-side register logic of a pluggable optical module's management port. A bit-level two-wire serial front end, which is not part of this block, hands it framing events (start, stop) and whole bytes. The block decodes the device address byte, keeps a byte pointer, stores written bytes and returns read bytes.

The 256-byte address space is split into two halves. The lower 128 bytes form one fixed page. It carries the time-critical status, flag and monitor bytes, and it is always reachable. The upper 128 bytes are a window onto one of several pages. The page is chosen by a page-select byte at the top of the lower page. By default, pages 0 (identification), 2 (free user storage) and 3 (thresholds) are built. Page 1 and any page number of 4 or more are unimplemented.

An active-low module-select input gates the whole block, so several modules can share one bus. While this input is high, the block answers nothing and changes nothing. It is expected to float high through a pull-up when not driven.

Top module: `mm_regif`

## Requirements
- R1: On reset, ack_o and rd_vld_o are 0, every stored byte reads 00h and the page-select byte (lower address 127) reads 00h.
- R2: After start_i, the first byte is a device address byte. A byte of A0h (write) or A1h (read) is acknowledged, with ack_o high in the cycle after the byte. Any other value is not acknowledged, and every later byte is ignored until the next start_i.
- R3: While mod_sel_ni is high, the block gives no ack_o and no rd_vld_o, and no stored byte, pointer or page-select value changes.
- R4: In a write transaction, the first byte after A0h loads the pointer. Each following byte is stored at the pointer, which then advances, and every such byte is acknowledged.
- R5: In a read transaction (after A1h), each rd_req_i returns the byte at the pointer on rd_byte_o, with rd_vld_o high one cycle later, and the pointer then advances.
- R6: Advancing the pointer from 127 gives 0, so it stays in the lower page.
- R7: Advancing the pointer from 255 gives 128, so it stays in the upper window.
- R8: A write to lower address 127 sets the page-select value, and reading address 127 returns it. Accesses to addresses 128 to 255 go to the page it names, starting with the next access.
- R9: Each implemented upper page keeps its own contents: the same upper address holds independent bytes on different pages.
- R10: When page select names an unimplemented page (1, or 4 and above), upper reads return 00h and upper writes are acknowledged but change no page.
- R11: A repeated start keeps the pointer, so a write of the pointer followed by a start and A1h reads from that pointer.
- R12: Lower-page bytes 0 to 126 read the same whatever the page-select value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mod_sel_ni | input | 1 | Module select, active low |
| start_i | input | 1 | Start or repeated-start event, one cycle |
| stop_i | input | 1 | Stop event, one cycle |
| wr_vld_i | input | 1 | A byte from the host is present on wr_byte_i |
| wr_byte_i | input | 8 | Byte from the host |
| ack_o | output | 1 | Acknowledge of the previous cycle's byte |
| rd_req_i | input | 1 | Host asks for the next read byte |
| rd_vld_o | output | 1 | rd_byte_o holds the requested byte |
| rd_byte_o | output | 8 | Byte returned to the host |

## Verification
The hardest case to reach is a write that goes to an unimplemented page. Its only visible effect is that nothing happens, so the check has to look elsewhere. The stimulus first fills page 0 at upper address 80h. It then selects page 1 and writes the same address, reads 00h there, switches back to page 0 and reads the original byte. A deselected burst is handled the same way. Address, pointer and data bytes are sent while mod_sel_ni is high, and the block is then selected again. Reading back the targeted byte and the page-select byte shows that nothing moved.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_PTR,
    PH_WDATA,
    PH_READ
  } phase_e;

  // advance the pointer without leaving the current half
  function automatic logic [BYTE_W-1:0] ptr_step(input logic [BYTE_W-1:0] p);
    return {p[BYTE_W-1], p[BYTE_W-2:0] + 1'b1};
  endfunction
endpackage

// File: rtl/mm_byte_bank.sv
module mm_byte_bank #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/mm_bus_fsm.sv
module mm_bus_fsm
  import mm_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wr_vld_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  input  logic              rd_req_i,
  output logic              ack_o,
  output logic              wr_en_o,
  output logic              rd_en_o,
  output logic [BYTE_W-1:0] ptr_o
);
  phase_e            phase_q;
  logic [BYTE_W-1:0] ptr_q;
  logic              ack_q;
  logic              live;

  assign live    = sel_i && !start_i && !stop_i;
  assign wr_en_o = live && wr_vld_i && (phase_q == PH_WDATA);
  assign rd_en_o = live && !wr_vld_i && rd_req_i && (phase_q == PH_READ);
  assign ptr_o   = ptr_q;
  assign ack_o   = ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      ptr_q   <= '0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      if (!sel_i) begin
        phase_q <= PH_IDLE;
      end else if (start_i) begin
        phase_q <= PH_ADDR;
      end else if (stop_i) begin
        phase_q <= PH_IDLE;
      end else if (wr_vld_i) begin
        unique case (phase_q)
          PH_ADDR: begin
            if (wr_byte_i[7:1] == DEV_ADDR) begin
              ack_q   <= 1'b1;
              phase_q <= wr_byte_i[0] ? PH_READ : PH_PTR;
            end else begin
              phase_q <= PH_IDLE;
            end
          end
          PH_PTR: begin
            ack_q   <= 1'b1;
            ptr_q   <= wr_byte_i;
            phase_q <= PH_WDATA;
          end
          PH_WDATA: begin
            ack_q <= 1'b1;
            ptr_q <= ptr_step(ptr_q);
          end
          default: ;
        endcase
      end else if (rd_en_o) begin
        ptr_q <= ptr_step(ptr_q);
      end
    end
  end
endmodule

// File: rtl/mm_regif.sv
module mm_regif
  import mm_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR  = 7'h50,
  parameter int unsigned NUM_PAGES = 4,
  parameter logic [NUM_PAGES-1:0] PAGE_MASK = 4'b1101,
  parameter int unsigned PAGE_SZ   = 128,
  localparam int unsigned PAW      = $clog2(PAGE_SZ),
  localparam logic [PAW-1:0] PSEL_ADDR = PAW'(PAGE_SZ - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mod_sel_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wr_vld_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  output logic              ack_o,
  input  logic              rd_req_i,
  output logic              rd_vld_o,
  output logic [BYTE_W-1:0] rd_byte_o
);
  logic              wr_en, rd_en;
  logic [BYTE_W-1:0] ptr;
  logic [BYTE_W-1:0] page_sel_q;
  logic [BYTE_W-1:0] lower_rd, upper_rd, rd_nxt;
  logic [BYTE_W-1:0] upper_rdata [NUM_PAGES];
  logic              upper_hit, lower_we, psel_hit;
  logic              rd_vld_q;
  logic [BYTE_W-1:0] rd_byte_q;

  mm_bus_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (!mod_sel_ni),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .wr_vld_i (wr_vld_i),
    .wr_byte_i(wr_byte_i),
    .rd_req_i (rd_req_i),
    .ack_o    (ack_o),
    .wr_en_o  (wr_en),
    .rd_en_o  (rd_en),
    .ptr_o    (ptr)
  );

  assign upper_hit = ptr[BYTE_W-1];
  assign psel_hit  = !upper_hit && (ptr[PAW-1:0] == PSEL_ADDR);
  assign lower_we  = wr_en && !upper_hit && !psel_hit;

  mm_byte_bank #(.DEPTH(PAGE_SZ), .DATA_W(BYTE_W)) u_lower (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (lower_we),
    .addr_i (ptr[PAW-1:0]),
    .wdata_i(wr_byte_i),
    .rdata_o(lower_rd)
  );

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    if (PAGE_MASK[p]) begin : g_impl
      logic bank_we;
      assign bank_we = wr_en && upper_hit && (page_sel_q == BYTE_W'(p));
      mm_byte_bank #(.DEPTH(PAGE_SZ), .DATA_W(BYTE_W)) u_bank (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (bank_we),
        .addr_i (ptr[PAW-1:0]),
        .wdata_i(wr_byte_i),
        .rdata_o(upper_rdata[p])
      );
    end else begin : g_hole
      assign upper_rdata[p] = '0;
    end
  end

  always_comb begin
    upper_rd = '0;
    for (int p = 0; p < NUM_PAGES; p++) begin
      if (page_sel_q == BYTE_W'(p)) upper_rd = upper_rdata[p];
    end
  end

  always_comb begin
    if (upper_hit)     rd_nxt = upper_rd;
    else if (psel_hit) rd_nxt = page_sel_q;
    else               rd_nxt = lower_rd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_sel_q <= '0;
      rd_vld_q   <= 1'b0;
      rd_byte_q  <= '0;
    end else begin
      rd_vld_q <= rd_en;
      if (rd_en) rd_byte_q <= rd_nxt;
      if (wr_en && psel_hit) page_sel_q <= wr_byte_i;
    end
  end

  assign rd_vld_o  = rd_vld_q;
  assign rd_byte_o = rd_byte_q;
endmodule

// File: rtl/mm_regif_chk.sv
module mm_regif_chk #(
  parameter int unsigned NUM_PAGES = 4,
  parameter logic [NUM_PAGES-1:0] PAGE_MASK = 4'b1101
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mod_sel_ni,
  input logic       wr_vld_i,
  input logic       rd_req_i,
  input logic       ack_o,
  input logic       rd_vld_o,
  input logic [7:0] rd_byte_o,
  input logic [7:0] page_sel_q,
  input logic [7:0] ptr,
  input logic       rd_en
);
  logic impl;
  always_comb begin
    impl = 1'b0;
    for (int p = 0; p < NUM_PAGES; p++)
      if (page_sel_q == 8'(p) && PAGE_MASK[p]) impl = 1'b1;
  end

  a_r2_ack_after_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(wr_vld_i));
  a_r3_desel_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_sel_ni |=> (!ack_o && !rd_vld_o));
  a_r3_desel_psel_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_sel_ni |=> $stable(page_sel_q));
  a_r5_rdvld_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o |-> $past(rd_req_i));
  a_r6_lower_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && ptr == 8'd127) |=> (ptr == 8'd0));
  a_r7_upper_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && ptr == 8'd255) |=> (ptr == 8'd128));
  a_r10_hole_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && ptr[7] && !impl) |=> (rd_byte_o == 8'h00));
endmodule

bind mm_regif mm_regif_chk #(.NUM_PAGES(NUM_PAGES), .PAGE_MASK(PAGE_MASK)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mod_sel_ni(mod_sel_ni),
  .wr_vld_i  (wr_vld_i),
  .rd_req_i  (rd_req_i),
  .ack_o     (ack_o),
  .rd_vld_o  (rd_vld_o),
  .rd_byte_o (rd_byte_o),
  .page_sel_q(page_sel_q),
  .ptr       (ptr),
  .rd_en     (rd_en)
);

// File: tb/mm_regif_bench.sv
module mm_regif_bench;
  logic       clk_i = 1'b0, rst_ni = 1'b0, mod_sel_ni = 1'b1;
  logic       start_i = 1'b0, stop_i = 1'b0, wr_vld_i = 1'b0, rd_req_i = 1'b0;
  logic [7:0] wr_byte_i = 8'h00;
  logic       ack_o, rd_vld_o;
  logic [7:0] rd_byte_o;

  int         n_run = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk_i = ~clk_i;

  mm_regif u_mm_regif (
    .clk_i(clk_i), .rst_ni(rst_ni), .mod_sel_ni(mod_sel_ni),
    .start_i(start_i), .stop_i(stop_i), .wr_vld_i(wr_vld_i),
    .wr_byte_i(wr_byte_i), .ack_o(ack_o), .rd_req_i(rd_req_i),
    .rd_vld_o(rd_vld_o), .rd_byte_o(rd_byte_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected bytes as the design returns them
  always @(negedge clk_i) begin
    if (rst_ni && rd_vld_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected rd_vld_o", rd_byte_o, 8'h00);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rd_byte_o == e, t, rd_byte_o, e);
      end
    end
  end

  task automatic do_start();
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk_i); stop_i = 1'b1;
    @(negedge clk_i); stop_i = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input bit exp_ack, input string tag);
    @(negedge clk_i); wr_vld_i = 1'b1; wr_byte_i = b;
    @(negedge clk_i); wr_vld_i = 1'b0;
    chk(ack_o == exp_ack, tag, {7'd0, ack_o}, {7'd0, exp_ack});
  endtask

  task automatic rd(input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk_i); rd_req_i = 1'b1;
    @(negedge clk_i); rd_req_i = 1'b0;
  endtask

  task automatic set_ptr(input logic [7:0] p);
    do_start();
    send(8'hA0, 1'b1, "R2 write address ack");
    send(p, 1'b1, "R4 pointer ack");
  endtask

  task automatic write_at(input logic [7:0] p, input logic [7:0] b);
    set_ptr(p);
    send(b, 1'b1, "R4 data ack");
    do_stop();
  endtask

  task automatic read_at(input logic [7:0] p, input logic [7:0] e, input string tag);
    set_ptr(p);
    do_start();
    send(8'hA1, 1'b1, "R11 read address ack");
    rd(e, tag);
    do_stop();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(ack_o == 1'b0, "R1 ack_o in reset", {7'd0, ack_o}, 8'h00);
    chk(rd_vld_o == 1'b0, "R1 rd_vld_o in reset", {7'd0, rd_vld_o}, 8'h00);
    rst_ni = 1'b1; mod_sel_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    read_at(8'h20, 8'h00, "R1 lower byte cleared");
    read_at(8'd127, 8'h00, "R1 page select cleared");
    read_at(8'h85, 8'h00, "R1 page 0 byte cleared");

    // R4 R5 R11: burst write then repeated-start burst read
    set_ptr(8'h10);
    send(8'h11, 1'b1, "R4 data ack");
    send(8'h22, 1'b1, "R4 data ack");
    send(8'h33, 1'b1, "R4 data ack");
    do_stop();
    set_ptr(8'h10);
    do_start();
    send(8'hA1, 1'b1, "R11 read address ack");
    rd(8'h11, "R5 burst byte 0");
    rd(8'h22, "R5 burst byte 1");
    rd(8'h33, "R5 burst byte 2");
    do_stop();

    // R2: foreign address is not acknowledged and what follows is ignored
    do_start();
    send(8'hA2, 1'b0, "R2 foreign address no ack");
    send(8'h10, 1'b0, "R2 ignored byte no ack");
    send(8'hEE, 1'b0, "R2 ignored byte no ack");
    do_stop();
    read_at(8'h10, 8'h11, "R2 foreign transfer wrote nothing");

    // R6 R8: write across 126,127,0; 127 becomes page select = 2
    set_ptr(8'd126);
    send(8'h5A, 1'b1, "R4 data ack");
    send(8'h02, 1'b1, "R8 page select write ack");
    send(8'h77, 1'b1, "R6 wrapped write ack");
    do_stop();
    set_ptr(8'd126);
    do_start();
    send(8'hA1, 1'b1, "R11 read address ack");
    rd(8'h5A, "R6 byte 126");
    rd(8'h02, "R8 page select readback");
    rd(8'h77, "R6 wrap to byte 0");
    do_stop();

    // R7: upper window wraps 255 -> 128 on page 2
    set_ptr(8'hFF);
    send(8'hAB, 1'b1, "R4 data ack");
    send(8'hCD, 1'b1, "R7 wrapped write ack");
    do_stop();
    set_ptr(8'hFF);
    do_start();
    send(8'hA1, 1'b1, "R11 read address ack");
    rd(8'hAB, "R7 byte 255");
    rd(8'hCD, "R7 wrap to byte 128");
    do_stop();

    // R9: pages hold independent data at the same address
    write_at(8'd127, 8'h00);
    write_at(8'h80, 8'h44);
    read_at(8'h80, 8'h44, "R9 page 0 byte 80h");
    write_at(8'd127, 8'h03);
    write_at(8'h80, 8'h99);
    read_at(8'h80, 8'h99, "R9 page 3 byte 80h");
    write_at(8'd127, 8'h02);
    read_at(8'h80, 8'hCD, "R9 page 2 byte 80h");

    // R10: unimplemented pages
    write_at(8'd127, 8'h01);
    write_at(8'h80, 8'hEE);
    read_at(8'h80, 8'h00, "R10 page 1 reads zero");
    read_at(8'h10, 8'h11, "R12 lower under page 1");
    write_at(8'd127, 8'h09);
    read_at(8'h81, 8'h00, "R10 page 9 reads zero");
    read_at(8'd126, 8'h5A, "R12 lower under page 9");
    write_at(8'd127, 8'h00);
    read_at(8'h80, 8'h44, "R10 page 0 untouched by hole write");

    // R3: deselected traffic is ignored
    mod_sel_ni = 1'b1;
    do_start();
    send(8'hA0, 1'b0, "R3 no ack when deselected");
    send(8'h10, 1'b0, "R3 no ack when deselected");
    send(8'hFF, 1'b0, "R3 no ack when deselected");
    @(negedge clk_i); rd_req_i = 1'b1;
    @(negedge clk_i); rd_req_i = 1'b0;
    chk(rd_vld_o == 1'b0, "R3 no read when deselected", {7'd0, rd_vld_o}, 8'h00);
    do_start();
    send(8'hA0, 1'b0, "R3 no ack when deselected");
    send(8'd127, 1'b0, "R3 no ack when deselected");
    send(8'h03, 1'b0, "R3 no ack when deselected");
    do_stop();
    mod_sel_ni = 1'b0;
    read_at(8'h10, 8'h11, "R3 byte unchanged after deselect");
    read_at(8'd127, 8'h00, "R3 page select unchanged");

    repeat (4) @(negedge clk_i);
    chk(exp_q.size() == 0, "R5 all reads returned", 8'(exp_q.size()), 8'h00);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule